// File: doc/BRIEF.md
# Frame-Aligned TDM Access Sequencer

This block is the master timing counter of a time-slot switching fabric. It runs from a 65.536 MHz clock and counts through one 125 µs frame of 8192 clocks. It presents the running count both as one 13-bit word and as three fields: time slot, stream and sub-state. Every other part of the switch keys its memory accesses to this count.

Each 64-clock time slot (976 ns) is divided into sixteen 4-clock access phases (61 ns each). The phase number is the stream field. A registered one-hot strobe vector grants a single shared memory port to one requester per phase. The requesters are the connection-memory reader, the host processor, the bus-side data reader and the bus-side data writer.

A synchronous 8 kHz frame pulse forces the count back to zero. If the pulse arrives anywhere other than the last count of the frame, a sticky misalignment flag is raised. A diagnostic port can clear the count or load it with any value, and counting then continues from there.

Top module: `tdm_state_seq`

## Requirements
- R1: While reset is active, the count, slot, stream and sub-state outputs are 0, the strobe vector is 4'b0001 and the misalignment flag is 0.
- R2: With no frame pulse and no diagnostic request, the count rises by one on each clock edge and wraps from 8191 to 0.
- R3: The slot output equals count bits [12:6], the stream output equals count bits [5:2] (the access phase), and the sub-state output equals count bits [1:0].
- R4: Exactly one strobe bit is high in every cycle, chosen by the phase p = count[5:2]. Bit 0 (connection-memory read) is high for even p. Bit 1 (host access) is high for p in {1,5,9,13}. Bit 2 (bus data read) is high for p in {3,11}. Bit 3 (bus data write) is high for p in {7,15}.
- R5: A frame pulse sampled on an edge with no diagnostic request makes the count 0 after that edge.
- R6: A frame pulse sampled with no diagnostic request while the count is not 8191 sets the misalignment flag after that edge. A pulse sampled while the count is 8191 leaves the flag unchanged.
- R7: The misalignment flag stays set until the clear input is sampled high. A set condition in the same cycle as the clear wins.
- R8: A diagnostic clear makes the count 0 after the edge. It takes priority over a diagnostic load and over the frame pulse, and while it is active the frame pulse cannot change the flag.
- R9: A diagnostic load without a diagnostic clear makes the count equal to the load value after the edge and takes priority over the frame pulse. Counting resumes from the loaded value, and the frame pulse cannot change the flag in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 65.536 MHz state clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_i | input | 1 | Synchronous frame pulse, one clock wide |
| diag_clr_i | input | 1 | Diagnostic request: clear the count |
| diag_ld_i | input | 1 | Diagnostic request: load the count |
| diag_val_i | input | 13 | Value for a diagnostic load |
| mis_clr_i | input | 1 | Clears the sticky misalignment flag |
| count_o | output | 13 | Packed count word |
| slot_o | output | 7 | Time-slot field |
| stream_o | output | 4 | Stream field, equal to the access phase |
| substate_o | output | 2 | Sub-state field |
| strobe_o | output | 4 | One-hot access grant per phase |
| misalign_o | output | 1 | Sticky flag: frame pulse seen at the wrong count |

## Verification
The assertions assume that every input is synchronous to the state clock. They also assume that the frame pulse and the diagnostic requests are level samples taken at each edge, and that the load value is stable while a load is requested. The bench drives every input at the falling edge, so each one is settled well before the rising edge that samples it. Random cycles mix rare frame pulses, clears and loads with long stretches of plain counting. Directed cases cover the wrap from 8191, a frame pulse placed exactly at 8191, a clear and a set in the same cycle, and requests that collide.

// File: rtl/tdm_seq_pkg.sv
package tdm_seq_pkg;

  localparam int unsigned STRB_N = 4;

  typedef enum logic [1:0] {
    OWN_CMRD  = 2'd0,
    OWN_CPU   = 2'd1,
    OWN_BUSRD = 2'd2,
    OWN_BUSWR = 2'd3
  } owner_e;

  // Low three phase bits select the owner: even -> CM read,
  // x01 -> host, 011 -> bus read, 111 -> bus write.
  function automatic owner_e phase_owner(input logic [2:0] ph_lo);
    owner_e o;
    if (!ph_lo[0])      o = OWN_CMRD;
    else if (!ph_lo[1]) o = OWN_CPU;
    else if (!ph_lo[2]) o = OWN_BUSRD;
    else                o = OWN_BUSWR;
    return o;
  endfunction

endpackage

// File: rtl/tdm_rst_sync.sv
module tdm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/tdm_seq_counter.sv
module tdm_seq_counter #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             diag_clr_i,
  input  logic             diag_ld_i,
  input  logic [CNT_W-1:0] diag_val_i,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic             at_max_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (diag_clr_i)     cnt_d = '0;
    else if (diag_ld_i) cnt_d = diag_val_i;
    else if (frame_i)   cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_q_o  = cnt_q;
  assign cnt_d_o  = cnt_d;
  assign at_max_o = (cnt_q == CNT_MAX);

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!diag_clr_i && !diag_ld_i && !frame_i && cnt_q != CNT_MAX)
      |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!diag_clr_i && !diag_ld_i && !frame_i && cnt_q == CNT_MAX) |=> cnt_q == '0);
  assert_frame_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!diag_clr_i && !diag_ld_i && frame_i) |=> cnt_q == '0);
  assert_diag_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diag_clr_i |=> cnt_q == '0);
  assert_diag_ld_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!diag_clr_i && diag_ld_i) |=> cnt_q == $past(diag_val_i));
endmodule

// File: rtl/tdm_phase_decode.sv
module tdm_phase_decode
  import tdm_seq_pkg::*;
#(
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned PH_LSB  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_d_i,
  output logic [STRB_N-1:0] strobe_o
);
  owner_e            own_d;
  logic [STRB_N-1:0] strobe_d, strobe_q;
  logic              strb_en;

  always_comb begin
    strb_en  = 1'b1;
    own_d    = phase_owner(cnt_d_i[PH_LSB+2:PH_LSB]);
    strobe_d = '0;
    strobe_d[own_d] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      strobe_q <= {{(STRB_N-1){1'b0}}, 1'b1};
    else if (strb_en) strobe_q <= strobe_d;
  end

  assign strobe_o = strobe_q;

  assert_one_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(strobe_q) == 1);
endmodule

// File: rtl/tdm_align_mon.sv
module tdm_align_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic diag_busy_i,
  input  logic at_max_i,
  input  logic clr_i,
  output logic misalign_o
);
  logic flag_q, flag_d, set_c;

  always_comb begin
    set_c = frame_i && !diag_busy_i && !at_max_i;
    if (set_c)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign misalign_o = flag_q;

  assert_late_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !diag_busy_i && !at_max_i) |=> flag_q);
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !frame_i) |=> !flag_q);
endmodule

// File: rtl/tdm_state_seq.sv
module tdm_state_seq
  import tdm_seq_pkg::*;
#(
  parameter int unsigned SLOT_W   = 7,
  parameter int unsigned STREAM_W = 4,
  parameter int unsigned SUB_W    = 2,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              frame_i,
  input  logic                              diag_clr_i,
  input  logic                              diag_ld_i,
  input  logic [SLOT_W+STREAM_W+SUB_W-1:0]  diag_val_i,
  input  logic                              mis_clr_i,
  output logic [SLOT_W+STREAM_W+SUB_W-1:0]  count_o,
  output logic [SLOT_W-1:0]                 slot_o,
  output logic [STREAM_W-1:0]               stream_o,
  output logic [SUB_W-1:0]                  substate_o,
  output logic [STRB_N-1:0]                 strobe_o,
  output logic                              misalign_o
);
  localparam int unsigned CNT_W  = SLOT_W + STREAM_W + SUB_W;
  localparam int unsigned STR_LO = SUB_W;
  localparam int unsigned SLT_LO = SUB_W + STREAM_W;

  logic             rst_n;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_max;

  tdm_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk_i (clk_i), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  tdm_seq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .frame_i(frame_i),
    .diag_clr_i(diag_clr_i), .diag_ld_i(diag_ld_i), .diag_val_i(diag_val_i),
    .cnt_q_o(cnt_q), .cnt_d_o(cnt_d), .at_max_o(at_max)
  );

  tdm_phase_decode #(.CNT_W(CNT_W), .PH_LSB(STR_LO)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_n), .cnt_d_i(cnt_d), .strobe_o(strobe_o)
  );

  tdm_align_mon u_mon (
    .clk_i(clk_i), .rst_ni(rst_n), .frame_i(frame_i),
    .diag_busy_i(diag_clr_i | diag_ld_i), .at_max_i(at_max),
    .clr_i(mis_clr_i), .misalign_o(misalign_o)
  );

  assign count_o    = cnt_q;
  assign slot_o     = cnt_q[CNT_W-1:SLT_LO];
  assign stream_o   = cnt_q[SLT_LO-1:STR_LO];
  assign substate_o = cnt_q[STR_LO-1:0];

  // Grant vector and count come from separate registers: check alignment.
  assert_even_cmrd_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cnt_q[STR_LO] |-> strobe_o[OWN_CMRD]);
  assert_host_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cnt_q[STR_LO+1:STR_LO] == 2'b01) |-> strobe_o[OWN_CPU]);
  assert_bus_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cnt_q[STR_LO+2:STR_LO] == 3'b111) |-> strobe_o[OWN_BUSWR]);
endmodule

// File: tb/tdm_state_seq_tb_top.sv
module tdm_state_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame, dclr, dld, mclr;
  logic [12:0] dval;
  logic [12:0] count;
  logic [6:0]  slot;
  logic [3:0]  stream;
  logic [1:0]  sub;
  logic [3:0]  strobe;
  logic        mis;

  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;
  logic [12:0] m_cnt;
  logic        m_mis;

  always #10 clk = ~clk;

  tdm_state_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .diag_clr_i(dclr),
    .diag_ld_i(dld), .diag_val_i(dval), .mis_clr_i(mclr),
    .count_o(count), .slot_o(slot), .stream_o(stream), .substate_o(sub),
    .strobe_o(strobe), .misalign_o(mis)
  );

  function automatic logic [3:0] exp_strobe(input logic [12:0] c);
    logic [3:0] p;
    p = c[5:2];
    case (p)
      4'd1, 4'd5, 4'd9, 4'd13: return 4'b0010;
      4'd3, 4'd11:             return 4'b0100;
      4'd7, 4'd15:             return 4'b1000;
      default:                 return 4'b0001;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " count"}, 32'(count), 32'(m_cnt));
    chk("R3 slot", 32'(slot), 32'(m_cnt[12:6]));
    chk("R3 stream", 32'(stream), 32'(m_cnt[5:2]));
    chk("R3 substate", 32'(sub), 32'(m_cnt[1:0]));
    chk("R4 strobe", 32'(strobe), 32'(exp_strobe(m_cnt)));
    chk("R6/R7 misalign", 32'(mis), 32'(m_mis));
  endtask

  task automatic step(input logic f, input logic dc, input logic dl,
                      input logic [12:0] dv, input logic mc, input string tag);
    frame = f; dclr = dc; dld = dl; dval = dv; mclr = mc;
    @(posedge clk);
    if (f && !dc && !dl && m_cnt != 13'h1fff) m_mis = 1'b1;
    else if (mc)                               m_mis = 1'b0;
    if (dc)      m_cnt = '0;
    else if (dl) m_cnt = dv;
    else if (f)  m_cnt = '0;
    else         m_cnt = m_cnt + 13'd1;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0, "R2");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    frame = 0; dclr = 0; dld = 0; dval = '0; mclr = 0;
    rst_n = 0;
    m_cnt = '0; m_mis = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", 32'(count), 0);
    chk("R1 strobe", 32'(strobe), 32'h1);
    chk("R1 misalign", 32'(mis), 0);
    chk("R1 fields", 32'({slot, stream, sub}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // align model with a diagnostic clear (R8)
    step(0, 1, 0, '0, 0, "R8 clear");
    m_mis = 0;
    chk("R1 misalign after release", 32'(mis), 0);

    // full frame of plain counting with wrap (R2)
    idle(8191);
    chk("R2 at max", 32'(count), 32'h1fff);
    step(1, 0, 0, '0, 0, "R5 aligned frame");
    chk("R6 aligned frame no flag", 32'(mis), 0);
    idle(8191);
    step(0, 0, 0, '0, 0, "R2 wrap");
    chk("R2 wrap to zero", 32'(count), 0);

    // late frame (R5, R6)
    idle(37);
    step(1, 0, 0, '0, 0, "R5 late frame");
    chk("R5 zero after frame", 32'(count), 0);
    chk("R6 flag set", 32'(mis), 1);
    idle(20);
    chk("R7 sticky", 32'(mis), 1);
    // clear and set in the same cycle: set wins (R7)
    step(1, 0, 0, '0, 1, "R7 set wins");
    chk("R7 set beats clear", 32'(mis), 1);
    step(0, 0, 0, '0, 1, "R7 clear");
    chk("R7 cleared", 32'(mis), 0);

    // load near the wrap and resume (R9)
    step(0, 0, 1, 13'h1ffd, 0, "R9 load");
    chk("R9 loaded", 32'(count), 32'h1ffd);
    idle(3);
    chk("R9 resume wrap", 32'(count), 0);
    // load beats frame, frame ignored for flag (R9)
    step(1, 0, 1, 13'h0abc, 0, "R9 load over frame");
    chk("R9 load over frame value", 32'(count), 32'h0abc);
    chk("R9 flag untouched", 32'(mis), 0);
    // clear beats load and frame (R8)
    step(1, 1, 1, 13'h1234, 0, "R8 clear priority");
    chk("R8 clear over load", 32'(count), 0);
    chk("R8 flag untouched", 32'(mis), 0);

    // walk every phase of one slot (R4)
    step(0, 0, 1, 13'h0140, 0, "R9 load");
    for (int p = 0; p < 16; p++) begin
      chk("R4 phase grant", 32'(strobe), 32'(exp_strobe({7'd5, 4'(p), 2'd0})));
      idle(4);
    end

    // constrained random mix
    for (int i = 0; i < 40000; i++) begin
      logic f, dc, dl, mc;
      f  = ($urandom % 700) == 0;
      dc = ($urandom % 3000) == 0;
      dl = ($urandom % 1500) == 0;
      mc = ($urandom % 300) == 0;
      step(f, dc, dl, 13'($urandom), mc, "R2 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule